// File: doc/BRIEF.md
# Address-Value Delta Load Predictor

This block predicts the value that a pointer-producing load would return when that load misses in the second-level cache while the core is running ahead speculatively. Many pointer loads keep a fixed distance between the address they read and the pointer they fetch. Nodes allocated back to back, or a record stored next to the string it points to, both behave this way. The block learns that distance for each load and turns it into a value the runahead pipeline can use to compute the next address in a chain of dependent misses.

A training port takes loads that retire in normal execution. For each one it takes the program counter, the effective address and the loaded value, and forms the delta as address minus value in two's complement. Deltas too large to belong to a pointer are dropped, which keeps data loads out of the table. A lookup port takes the program counter and effective address of a load that missed during runahead. One cycle later it returns a predicted value, which is the address minus the stored delta, and a flag that marks the prediction as usable. The caller qualifies both ports. Lookups never change the table, so a wrong prediction needs no repair. The table is set-associative and uses least-recently-trained replacement, and each entry carries a small saturating confidence count.

Top module: `avd_predictor`

## Requirements
- R1: While reset is asserted and after it is released, no prediction is reported until an entry has become confident. Whenever `pred_valid` is 0, `pred_value` is 0.
- R2: The delta is `tr_ea - tr_data` modulo 2^ADDR_W, read as a signed number. A training request changes the table only when -MAX_AVD < delta < +MAX_AVD (MAX_AVD defaults to 65536). A request outside that window has no effect on any entry or on the replacement order.
- R3: A newly allocated entry starts at confidence 0. A training hit with the same delta raises confidence by one, saturating at 3. A hit with a different delta stores the new delta and sets confidence to 0. Only an entry at confidence 3 produces a prediction.
- R4: A lookup issued in cycle t sets `pred_valid` and `pred_value` after the clock edge that ends cycle t. On a confident hit the value is `lk_ea` minus the stored delta, modulo 2^ADDR_W.
- R5: The 16 entries form 4 sets of 4 ways. The set is `pc[1:0]` and the tag is `pc[31:2]`. Up to four distinct PCs that share a set are held at the same time, each with its own delta.
- R6: A training miss inside the window allocates an entry. It takes an empty way first. When the set is full it takes the way trained least recently. A training hit makes its way the most recent. Lookups leave both the contents and the replacement order unchanged.
- R7: When a training write and a lookup reach the same entry in the same cycle, the lookup returns what the entry held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tr_req | input | 1 | A load is retiring in normal execution |
| tr_pc | input | 32 | PC of the retiring load |
| tr_ea | input | 32 | Effective address of the retiring load |
| tr_data | input | 32 | Value returned by the retiring load |
| lk_req | input | 1 | A load missed in L2 during runahead |
| lk_pc | input | 32 | PC of the missing load |
| lk_ea | input | 32 | Effective address of the missing load |
| pred_valid | output | 1 | A confident prediction is available (registered) |
| pred_value | output | 32 | Predicted loaded value, 0 when not valid |

## Verification
The bench fills every way of every set with its own delta. The deltas cover negative and positive values, and each is looked up at several addresses, including ones that wrap around zero. A wrong index, tag split or subtraction shows up as a wrong value for a specific set and way. Confidence is probed after each of the first four trainings and after a changed delta, which separates a threshold error from a reset error. The deltas exactly at the window edges and one step inside them show whether the filter is off by one. Evicting a set after a training refresh, with repeated lookups in between, separates true recency order from fill order and from lookup-driven updates. A same-cycle train and lookup on one entry shows whether the read path sees the old or the new contents.

// File: rtl/avd_pkg.sv
package avd_pkg;
  // Width of the per-entry confidence counter
  localparam int CONF_W = 2;
  // Saturation value; an entry at this value is confident
  localparam logic [CONF_W-1:0] CONF_TOP = '1;
endpackage

// File: rtl/avd_delta_filter.sv
// Forms address minus value and decides whether it can belong to a pointer.
module avd_delta_filter #(
  parameter int ADDR_W  = 32,
  parameter int MAX_AVD = 65536,
  parameter int AVD_W   = 17
) (
  input  logic [ADDR_W-1:0] ea,
  input  logic [ADDR_W-1:0] data,
  output logic              in_range,
  output logic [AVD_W-1:0]  avd
);
  localparam logic signed [ADDR_W-1:0] POS_LIM = ADDR_W'(MAX_AVD);
  localparam logic signed [ADDR_W-1:0] NEG_LIM = -POS_LIM;

  logic [ADDR_W-1:0] delta;

  always_comb begin
    delta    = ea - data;
    in_range = ($signed(delta) < POS_LIM) && ($signed(delta) > NEG_LIM);
    // Lossless truncation: the window fits the narrow signed field
    avd      = delta[AVD_W-1:0];
  end
endmodule

// File: rtl/avd_lru_order.sv
// Per-set recency ages; age WAYS-1 marks the least recently trained way.
module avd_lru_order #(
  parameter int SETS  = 4,
  parameter int WAYS  = 4,
  parameter int IDX_W = 2,
  parameter int WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_set,
  input  logic [WAY_W-1:0] touch_way,
  input  logic [IDX_W-1:0] q_set,
  output logic [WAY_W-1:0] victim_way
);
  logic [WAY_W-1:0] age_q [SETS][WAYS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic             upd;
    logic [WAY_W-1:0] ref_age;
    logic [WAY_W-1:0] age_d [WAYS];

    always_comb begin
      upd     = touch_en && (touch_set == IDX_W'(s));
      ref_age = age_q[s][touch_way];
      for (int v = 0; v < WAYS; v++) begin
        if (WAY_W'(v) == touch_way) begin
          age_d[v] = '0;
        end else if (age_q[s][v] < ref_age) begin
          age_d[v] = age_q[s][v] + 1'b1;
        end else begin
          age_d[v] = age_q[s][v];
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int v = 0; v < WAYS; v++) begin
          age_q[s][v] <= WAY_W'(v);
        end
      end else if (upd) begin
        age_q[s] <= age_d;
      end
    end
  end

  always_comb begin
    victim_way = '0;
    for (int v = 0; v < WAYS; v++) begin
      if (age_q[q_set][v] == WAY_W'(WAYS - 1)) begin
        victim_way = WAY_W'(v);
      end
    end
  end
endmodule

// File: rtl/avd_entry_table.sv
// Tag, delta and confidence storage with a training search port,
// a lookup search port and one write port.
module avd_entry_table #(
  parameter int SETS   = 4,
  parameter int WAYS   = 4,
  parameter int IDX_W  = 2,
  parameter int WAY_W  = 2,
  parameter int TAG_W  = 30,
  parameter int AVD_W  = 17,
  parameter int CONF_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  // training search
  input  logic [IDX_W-1:0]     tr_set,
  input  logic [TAG_W-1:0]     tr_tag,
  output logic                 tr_hit,
  output logic [WAY_W-1:0]     tr_hit_way,
  output logic [AVD_W-1:0]     tr_avd_old,
  output logic [CONF_W-1:0]    tr_conf_old,
  output logic                 tr_free,
  output logic [WAY_W-1:0]     tr_free_way,
  // lookup search
  input  logic [IDX_W-1:0]     lk_set,
  input  logic [TAG_W-1:0]     lk_tag,
  output logic                 lk_hit,
  output logic [AVD_W-1:0]     lk_avd,
  output logic [CONF_W-1:0]    lk_conf,
  // write
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_set,
  input  logic [WAY_W-1:0]     wr_way,
  input  logic [TAG_W-1:0]     wr_tag,
  input  logic [AVD_W-1:0]     wr_avd,
  input  logic [CONF_W-1:0]    wr_conf,
  output logic [SETS*WAYS-1:0] valid_flat
);
  logic [WAYS-1:0]   valid_q [SETS];
  logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
  logic [AVD_W-1:0]  avd_q   [SETS][WAYS];
  logic [CONF_W-1:0] conf_q  [SETS][WAYS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic sel;
      always_comb sel = wr_en && (wr_set == IDX_W'(s)) && (wr_way == WAY_W'(w));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          valid_q[s][w] <= 1'b0;
        end else if (sel) begin
          valid_q[s][w] <= 1'b1;
        end
      end

      always_ff @(posedge clk) begin
        if (sel) begin
          tag_q[s][w]  <= wr_tag;
          avd_q[s][w]  <= wr_avd;
          conf_q[s][w] <= wr_conf;
        end
      end
    end
    assign valid_flat[s*WAYS +: WAYS] = valid_q[s];
  end

  always_comb begin
    tr_hit      = 1'b0;
    tr_hit_way  = '0;
    tr_avd_old  = '0;
    tr_conf_old = '0;
    tr_free     = 1'b0;
    tr_free_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!tr_hit && valid_q[tr_set][w] && (tag_q[tr_set][w] == tr_tag)) begin
        tr_hit      = 1'b1;
        tr_hit_way  = WAY_W'(w);
        tr_avd_old  = avd_q[tr_set][w];
        tr_conf_old = conf_q[tr_set][w];
      end
      if (!tr_free && !valid_q[tr_set][w]) begin
        tr_free     = 1'b1;
        tr_free_way = WAY_W'(w);
      end
    end
  end

  always_comb begin
    lk_hit  = 1'b0;
    lk_avd  = '0;
    lk_conf = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!lk_hit && valid_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag)) begin
        lk_hit  = 1'b1;
        lk_avd  = avd_q[lk_set][w];
        lk_conf = conf_q[lk_set][w];
      end
    end
  end
endmodule

// File: rtl/avd_predictor.sv
// Address-value delta predictor top: training update and registered lookup.
module avd_predictor #(
  parameter int PC_W        = 32,
  parameter int ADDR_W      = 32,
  parameter int NUM_ENTRIES = 16,
  parameter int WAYS        = 4,    // power of two, at least 2
  parameter int MAX_AVD     = 65536
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tr_req,
  input  logic [PC_W-1:0]   tr_pc,
  input  logic [ADDR_W-1:0] tr_ea,
  input  logic [ADDR_W-1:0] tr_data,
  input  logic              lk_req,
  input  logic [PC_W-1:0]   lk_pc,
  input  logic [ADDR_W-1:0] lk_ea,
  output logic              pred_valid,
  output logic [ADDR_W-1:0] pred_value
);
  import avd_pkg::*;

  localparam int SETS  = NUM_ENTRIES / WAYS;
  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = PC_W - IDX_W;
  localparam int AVD_W = $clog2(MAX_AVD) + 1;

  // ---------------- reset release synchronizer ----------------
  logic [1:0] rst_pipe_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign core_rst_n = rst_pipe_q[1];

  // ---------------- index / tag split ----------------
  logic [IDX_W-1:0] tr_set, lk_set;
  logic [TAG_W-1:0] tr_tag, lk_tag;

  assign tr_set = tr_pc[IDX_W-1:0];
  assign tr_tag = tr_pc[PC_W-1:IDX_W];
  assign lk_set = lk_pc[IDX_W-1:0];
  assign lk_tag = lk_pc[PC_W-1:IDX_W];

  // ---------------- delta filter ----------------
  logic             tr_in_range;
  logic [AVD_W-1:0] tr_avd;

  avd_delta_filter #(
    .ADDR_W (ADDR_W),
    .MAX_AVD(MAX_AVD),
    .AVD_W  (AVD_W)
  ) u_filter (
    .ea      (tr_ea),
    .data    (tr_data),
    .in_range(tr_in_range),
    .avd     (tr_avd)
  );

  // ---------------- table ----------------
  logic                 tr_hit, tr_free, lk_hit;
  logic [WAY_W-1:0]     tr_hit_way, tr_free_way, victim_way;
  logic [AVD_W-1:0]     tr_avd_old, lk_avd;
  logic [CONF_W-1:0]    tr_conf_old, lk_conf;
  logic                 wr_en;
  logic [WAY_W-1:0]     wr_way;
  logic [AVD_W-1:0]     wr_avd;
  logic [CONF_W-1:0]    wr_conf;
  logic [NUM_ENTRIES-1:0] valid_flat;

  avd_entry_table #(
    .SETS  (SETS),
    .WAYS  (WAYS),
    .IDX_W (IDX_W),
    .WAY_W (WAY_W),
    .TAG_W (TAG_W),
    .AVD_W (AVD_W),
    .CONF_W(CONF_W)
  ) u_table (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .tr_set     (tr_set),
    .tr_tag     (tr_tag),
    .tr_hit     (tr_hit),
    .tr_hit_way (tr_hit_way),
    .tr_avd_old (tr_avd_old),
    .tr_conf_old(tr_conf_old),
    .tr_free    (tr_free),
    .tr_free_way(tr_free_way),
    .lk_set     (lk_set),
    .lk_tag     (lk_tag),
    .lk_hit     (lk_hit),
    .lk_avd     (lk_avd),
    .lk_conf    (lk_conf),
    .wr_en      (wr_en),
    .wr_set     (tr_set),
    .wr_way     (wr_way),
    .wr_tag     (tr_tag),
    .wr_avd     (wr_avd),
    .wr_conf    (wr_conf),
    .valid_flat (valid_flat)
  );

  // ---------------- replacement order ----------------
  avd_lru_order #(
    .SETS (SETS),
    .WAYS (WAYS),
    .IDX_W(IDX_W),
    .WAY_W(WAY_W)
  ) u_lru (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .touch_en  (wr_en),
    .touch_set (tr_set),
    .touch_way (wr_way),
    .q_set     (tr_set),
    .victim_way(victim_way)
  );

  // ---------------- training next state ----------------
  always_comb begin
    wr_en   = tr_req && tr_in_range;
    wr_way  = tr_free ? tr_free_way : victim_way;
    wr_avd  = tr_avd;
    wr_conf = '0;
    if (tr_hit) begin
      wr_way = tr_hit_way;
      if (tr_avd_old == tr_avd) begin
        wr_avd  = tr_avd_old;
        wr_conf = (tr_conf_old == CONF_TOP) ? CONF_TOP : tr_conf_old + 1'b1;
      end
    end
  end

  // ---------------- lookup result ----------------
  logic              pred_valid_q, pred_valid_d;
  logic [ADDR_W-1:0] pred_value_q, pred_value_d;
  logic              pred_en;

  always_comb begin
    pred_en      = lk_req || pred_valid_q;
    pred_valid_d = lk_req && lk_hit && (lk_conf == CONF_TOP);
    pred_value_d = '0;
    if (pred_valid_d) begin
      pred_value_d = lk_ea - {{(ADDR_W-AVD_W){lk_avd[AVD_W-1]}}, lk_avd};
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      pred_valid_q <= 1'b0;
      pred_value_q <= '0;
    end else if (pred_en) begin
      pred_valid_q <= pred_valid_d;
      pred_value_q <= pred_value_d;
    end
  end

  assign pred_valid = pred_valid_q;
  assign pred_value = pred_value_q;
endmodule

// File: rtl/avd_predictor_chk.sv
// Property checker for avd_predictor, bound below.
module avd_predictor_chk #(
  parameter int ADDR_W   = 32,
  parameter int MAX_AVD  = 65536,
  parameter int NUM_BITS = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                tr_req,
  input logic [ADDR_W-1:0]   tr_ea,
  input logic [ADDR_W-1:0]   tr_data,
  input logic                lk_req,
  input logic [ADDR_W-1:0]   lk_ea,
  input logic                pred_valid,
  input logic [ADDR_W-1:0]   pred_value,
  input logic [NUM_BITS-1:0] valid_bits
);
  localparam logic signed [ADDR_W-1:0] LIM = ADDR_W'(MAX_AVD);

  logic [ADDR_W-1:0] lk_ea_q;
  logic [ADDR_W-1:0] pred_gap, tr_gap;
  logic              pred_gap_ok, tr_gap_ok;

  always_ff @(posedge clk) lk_ea_q <= lk_ea;

  always_comb begin
    pred_gap    = lk_ea_q - pred_value;
    tr_gap      = tr_ea - tr_data;
    pred_gap_ok = ($signed(pred_gap) < LIM) && ($signed(pred_gap) > -LIM);
    tr_gap_ok   = ($signed(tr_gap) < LIM) && ($signed(tr_gap) > -LIM);
  end

  // R1
  idle_value_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_valid |-> (pred_value == '0));

  // R4
  pred_from_lookup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pred_valid |-> $past(lk_req));

  // R4
  pred_gap_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pred_valid |-> pred_gap_ok);

  // R2
  far_delta_no_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tr_req && !tr_gap_ok) |=> $stable(valid_bits));

  // R6
  lookup_no_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tr_req |=> $stable(valid_bits));
endmodule

bind avd_predictor avd_predictor_chk #(
  .ADDR_W  (ADDR_W),
  .MAX_AVD (MAX_AVD),
  .NUM_BITS(NUM_ENTRIES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tr_req    (tr_req),
  .tr_ea     (tr_ea),
  .tr_data   (tr_data),
  .lk_req    (lk_req),
  .lk_ea     (lk_ea),
  .pred_valid(pred_valid),
  .pred_value(pred_value),
  .valid_bits(valid_flat)
);

// File: tb/avd_predictor_tb.sv
module avd_predictor_tb;
  localparam int MAXD = 65536;

  logic        clk;
  logic        rst_n;
  logic        tr_req, lk_req;
  logic [31:0] tr_pc, tr_ea, tr_data, lk_pc, lk_ea;
  logic        pred_valid;
  logic [31:0] pred_value;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  avd_predictor u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .tr_req    (tr_req),
    .tr_pc     (tr_pc),
    .tr_ea     (tr_ea),
    .tr_data   (tr_data),
    .lk_req    (lk_req),
    .lk_pc     (lk_pc),
    .lk_ea     (lk_ea),
    .pred_valid(pred_valid),
    .pred_value(pred_value)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] mkpc(int s, int t);
    return (32'(t) << 2) | 32'(s);
  endfunction

  function automatic int base_avd(int s, int w);
    return (s * 4 + w) * 1000 - 7000;
  endfunction

  task automatic expect_pred(input string req, input logic gv, input logic [31:0] gval,
                             input logic ev, input logic [31:0] eval);
    n_cmp++;
    if (gv !== ev || gval !== eval) begin
      n_bad++;
      $display("FAIL %s: got valid=%0b value=%h, expected valid=%0b value=%h",
               req, gv, gval, ev, eval);
    end
  endtask

  // one request cycle, result sampled one edge later
  task automatic step(input logic tv, input logic [31:0] tpc, input logic [31:0] tea,
                      input logic [31:0] tdat, input logic lv, input logic [31:0] lpc,
                      input logic [31:0] lea, output logic pv, output logic [31:0] pval);
    @(negedge clk);
    tr_req = tv; tr_pc = tpc; tr_ea = tea; tr_data = tdat;
    lk_req = lv; lk_pc = lpc; lk_ea = lea;
    @(negedge clk);
    pv = pred_valid; pval = pred_value;
    tr_req = 1'b0; lk_req = 1'b0;
  endtask

  task automatic train(input logic [31:0] pc, input logic [31:0] ea, input int d);
    logic v; logic [31:0] x;
    step(1'b1, pc, ea, ea - 32'(d), 1'b0, 32'h0, 32'h0, v, x);
  endtask

  task automatic look(input string req, input logic [31:0] pc, input logic [31:0] ea,
                      input logic ev, input int d);
    logic v; logic [31:0] x;
    step(1'b0, 32'h0, 32'h0, 32'h0, 1'b1, pc, ea, v, x);
    expect_pred(req, v, x, ev, ev ? (ea - 32'(d)) : 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got running, expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    tr_req = 0; lk_req = 0; tr_pc = 0; tr_ea = 0; tr_data = 0; lk_pc = 0; lk_ea = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    expect_pred("R1 reset", pred_valid, pred_value, 1'b0, 32'h0);
    look("R1 empty lookup", mkpc(0, 1), 32'h1234_0000, 1'b0, 0);

    // R3/R5: fill every way, probing confidence after each training
    for (int s = 0; s < 4; s++) begin
      for (int w = 0; w < 4; w++) begin
        for (int k = 1; k <= 4; k++) begin
          train(mkpc(s, w + 1), 32'h0040_0000 + 32'((s * 4 + w) * 256), base_avd(s, w));
          look("R3 confidence ramp", mkpc(s, w + 1), 32'h1000_0000 + 32'(k * 64),
               k == 4, base_avd(s, w));
        end
      end
    end

    // R4/R5: value sweep over all entries, including wrapping addresses
    for (int s = 0; s < 4; s++) begin
      for (int w = 0; w < 4; w++) begin
        look("R4 value at 0", mkpc(s, w + 1), 32'h0000_0000, 1'b1, base_avd(s, w));
        look("R5 value mid", mkpc(s, w + 1), 32'h8000_0000, 1'b1, base_avd(s, w));
        look("R4 value top", mkpc(s, w + 1), 32'hFFFF_FFF0, 1'b1, base_avd(s, w));
      end
    end

    // R2: deltas exactly on the window edges are ignored
    for (int k = 0; k < 4; k++) train(mkpc(1, 9), 32'h0050_0000, MAXD);
    for (int k = 0; k < 4; k++) train(mkpc(1, 9), 32'h0050_0000, -MAXD);
    look("R2 edge ignored", mkpc(1, 9), 32'h0050_0000, 1'b0, 0);
    for (int w = 0; w < 4; w++)
      look("R2 set untouched", mkpc(1, w + 1), 32'h0000_0100, 1'b1, base_avd(1, w));

    // R2/R6: one step inside the window is learned, evicting the oldest way
    for (int k = 0; k < 4; k++) train(mkpc(2, 10), 32'h0060_0000, MAXD - 1);
    look("R2 inner positive", mkpc(2, 10), 32'h0060_0000, 1'b1, MAXD - 1);
    look("R6 oldest evicted", mkpc(2, 1), 32'h0060_0000, 1'b0, 0);
    look("R6 others kept", mkpc(2, 2), 32'h0060_0000, 1'b1, base_avd(2, 1));

    // R3: changed delta drops confidence, then rebuilds
    train(mkpc(2, 10), 32'h0060_0000, -(MAXD - 1));
    look("R3 changed delta", mkpc(2, 10), 32'h0060_0000, 1'b0, 0);
    for (int k = 0; k < 2; k++) train(mkpc(2, 10), 32'h0060_0000, -(MAXD - 1));
    look("R3 two matches", mkpc(2, 10), 32'h0060_0000, 1'b0, 0);
    train(mkpc(2, 10), 32'h0060_0000, -(MAXD - 1));
    look("R2 inner negative", mkpc(2, 10), 32'h0060_0000, 1'b1, -(MAXD - 1));

    // R6: training refreshes recency, lookups do not
    train(mkpc(0, 1), 32'h0070_0000, base_avd(0, 0));
    for (int k = 0; k < 5; k++)
      look("R6 lookup no refresh", mkpc(0, 2), 32'h0070_0000, 1'b1, base_avd(0, 1));
    for (int k = 0; k < 4; k++) train(mkpc(0, 12), 32'h0070_0000, 123);
    look("R6 least recent gone", mkpc(0, 2), 32'h0070_0000, 1'b0, 0);
    look("R6 refreshed kept", mkpc(0, 1), 32'h0070_0000, 1'b1, base_avd(0, 0));
    look("R6 way kept", mkpc(0, 3), 32'h0070_0000, 1'b1, base_avd(0, 2));
    look("R6 way kept", mkpc(0, 4), 32'h0070_0000, 1'b1, base_avd(0, 3));
    look("R6 new entry", mkpc(0, 12), 32'h0070_0000, 1'b1, 123);

    // R7: same-cycle train and lookup on one entry
    begin
      logic v; logic [31:0] x;
      step(1'b1, mkpc(0, 3), 32'h0080_0000, 32'h0080_0000 - 32'(base_avd(0, 2) + 8),
           1'b1, mkpc(0, 3), 32'h0090_0000, v, x);
      expect_pred("R7 pre-update read", v, x, 1'b1, 32'h0090_0000 - 32'(base_avd(0, 2)));
    end
    look("R7 update applied", mkpc(0, 3), 32'h0090_0000, 1'b0, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule